// File: doc/BRIEF.md
# Masked Priority Interrupt Resolver

This block picks, among up to 64 interrupt sources, the one that should be serviced next on the normal (non-fast) interrupt path, and decides whether the processor's interrupt request line should be raised. Every source has a 4-bit priority. The priorities arrive as packed 32-bit words, eight sources to a word. A per-source eligibility vector tells the resolver which sources are pending, enabled and routed to the normal path. That vector is formed outside the block.

The winner is the eligible source with the largest priority value. When two or more eligible sources share that value, the source with the highest index wins. A 5-bit mask threshold gates the request line. At its all-ones value the threshold masks nothing. At any other value, only a winner whose priority is strictly above the threshold raises the request. The results come from one output register stage, so every output follows its inputs with one clock of latency. A packed status word gives the winner's index and priority in fixed bit fields, or all ones when nothing is eligible.

Top module: `prio_irq_resolver`

## Requirements
- R1: All outputs are registered. A change at the inputs shows at the outputs after exactly one rising clock edge, and not before it. While reset is asserted, irq_o and win_vld_o are 0, and win_idx_o, win_prio_o and win_packed_o are all ones.
- R2: The priority of source n is bits [4*(n%8)+3 : 4*(n%8)] of word n/8. Word w occupies bits [32*w+31 : 32*w] of prio_words_i.
- R3: When at least one source is eligible, win_vld_o is 1 and win_idx_o/win_prio_o give the eligible source with the largest priority value and that source's priority.
- R4: Among eligible sources that share the largest priority, the one with the highest index is reported.
- R5: When no source is eligible, win_vld_o and irq_o are 0, win_idx_o is 6'h3F, win_prio_o is 4'hF and win_packed_o is 32'hFFFF_FFFF.
- R6: When win_vld_o is 1, win_packed_o carries win_idx_o in bits 21:16 and win_prio_o in bits 3:0, with all other bits zero.
- R7: With mask_i equal to 5'h1F, irq_o is 1 whenever any source is eligible, including when every eligible priority is 0.
- R8: With mask_i below 5'h1F, irq_o is 1 only if some eligible source has a priority strictly greater than mask_i. A priority equal to the mask does not raise it.
- R9: With mask_i from 16 to 30, irq_o stays 0 whatever the eligible sources and priorities are.
- R10: Priorities of sources that are not eligible have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| elig_i | input | 64 | Per-source eligibility (pending, enabled, normal path) |
| prio_words_i | input | 256 | Eight packed priority words, word w at bits 32w+31:32w |
| mask_i | input | 5 | Priority threshold; 5'h1F disables masking |
| irq_o | output | 1 | Normal interrupt request level |
| win_vld_o | output | 1 | A winner exists |
| win_idx_o | output | 6 | Index of the winning source |
| win_prio_o | output | 4 | Priority of the winning source |
| win_packed_o | output | 32 | Packed status: index in 21:16, priority in 3:0, all ones if none |

## Verification
The bench places eligible sources with equal top priority at the low, middle and high ends of the index range. A tie-break that favoured the lowest index, or that depended on position in the tree, would report the wrong source. It sets the mask equal to the winning priority and one below it. A comparison written as greater-or-equal would raise the request in the equal case. It also covers the all-ones mask with only priority-0 sources eligible, where a design that applies the comparison anyway would keep the line low, and mask values 16 and 30, where a truncated 4-bit compare would fire. Further cases check that a high-priority source that is not eligible cannot win, and that the outputs hold their old value until the clock edge. A seeded sweep of mixed patterns is compared against a source-by-source reference scan.

// File: rtl/prir_pkg.sv
package prir_pkg;
  localparam int SRC_CNT  = 64;
  localparam int PRIO_W   = 4;
  localparam int WORD_W   = 32;
  localparam int MASK_W   = 5;
  localparam int PACK_W   = 32;
  localparam int IDX_LSB  = 16;
  localparam int IDX_W    = $clog2(SRC_CNT);
  localparam int PER_WORD = WORD_W / PRIO_W;

  typedef struct packed {
    logic              irq;
    logic              vld;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] prio;
  } prir_res_t;
endpackage

// File: rtl/prir_unpack.sv
module prir_unpack #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int WORD_W  = 32,
  localparam int PER_WORD = WORD_W / PRIO_W,
  localparam int NUM_WORD = NUM_SRC / PER_WORD
) (
  input  logic [NUM_WORD*WORD_W-1:0] words_i,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_o
);
  // Source n: word n/PER_WORD, field n%PER_WORD within that word
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int WRD = n / PER_WORD;
    localparam int FLD = n % PER_WORD;
    assign prio_o[n*PRIO_W +: PRIO_W] = words_i[WRD*WORD_W + FLD*PRIO_W +: PRIO_W];
  end
endmodule

// File: rtl/prir_tree.sv
module prir_tree #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int LEVELS = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        elig_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      win_vld_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [PRIO_W-1:0]         win_prio_o
);
  // Level l holds NUM_SRC>>l candidates; node j of level l covers a contiguous index range,
  // with its right child always covering the higher indices.
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int W = NUM_SRC >> l;
    logic [W-1:0]        vld;
    logic [W*PRIO_W-1:0] prio;
    logic [W*IDX_W-1:0]  idx;
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_in
        assign vld[i]                   = elig_i[i];
        assign prio[i*PRIO_W +: PRIO_W] = prio_i[i*PRIO_W +: PRIO_W];
        assign idx[i*IDX_W +: IDX_W]    = IDX_W'(i);
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_cmp
        logic [PRIO_W+IDX_W-1:0] key_l, key_r;
        logic                    take_r;
        assign key_l  = {g_lvl[l-1].prio[(2*j)*PRIO_W +: PRIO_W],   g_lvl[l-1].idx[(2*j)*IDX_W +: IDX_W]};
        assign key_r  = {g_lvl[l-1].prio[(2*j+1)*PRIO_W +: PRIO_W], g_lvl[l-1].idx[(2*j+1)*IDX_W +: IDX_W]};
        // Index as low-order key: equal priorities resolve to the larger index
        assign take_r = g_lvl[l-1].vld[2*j+1] & (~g_lvl[l-1].vld[2*j] | (key_r > key_l));
        assign vld[j] = g_lvl[l-1].vld[2*j] | g_lvl[l-1].vld[2*j+1];
        assign prio[j*PRIO_W +: PRIO_W] = take_r ? key_r[IDX_W +: PRIO_W] : key_l[IDX_W +: PRIO_W];
        assign idx[j*IDX_W +: IDX_W]    = take_r ? key_r[IDX_W-1:0]       : key_l[IDX_W-1:0];
      end
    end
  end

  assign win_vld_o  = g_lvl[LEVELS].vld[0];
  assign win_idx_o  = g_lvl[LEVELS].idx[IDX_W-1:0];
  assign win_prio_o = g_lvl[LEVELS].prio[PRIO_W-1:0];

  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> elig_i[win_idx_o]); // R10
  AST_VALID_IFF_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o == (|elig_i)); // R3
  AST_WINNER_PRIO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> (prio_i[win_idx_o*PRIO_W +: PRIO_W] == win_prio_o)); // R2
endmodule

// File: rtl/prir_irq_gate.sv
module prir_irq_gate #(
  parameter int PRIO_W = 4,
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic [PRIO_W-1:0] max_prio_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              irq_o
);
  localparam logic [MASK_W-1:0] MASK_OPEN = '1;
  localparam logic [MASK_W-1:0] PRIO_TOP  = MASK_W'((1 << PRIO_W) - 1);

  logic open_mask, above;

  always_comb begin
    open_mask = (mask_i == MASK_OPEN);
    above     = (MASK_W'(max_prio_i) > mask_i);
    irq_o     = any_i & (open_mask | above);
  end

  AST_OPEN_MASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_i == MASK_OPEN) && any_i) |-> irq_o); // R7
  AST_HIGH_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_i != MASK_OPEN) && (mask_i > PRIO_TOP)) |-> !irq_o); // R9
  AST_NO_IRQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_i |-> !irq_o); // R8
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import prir_pkg::*;
#(
  parameter int NUM_SRC = SRC_CNT,
  localparam int NUM_WORD = NUM_SRC / PER_WORD
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        elig_i,
  input  logic [NUM_WORD*WORD_W-1:0] prio_words_i,
  input  logic [MASK_W-1:0]         mask_i,
  output logic                      irq_o,
  output logic                      win_vld_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [PRIO_W-1:0]         win_prio_o,
  output logic [PACK_W-1:0]         win_packed_o
);
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      t_vld;
  logic [IDX_W-1:0]          t_idx;
  logic [PRIO_W-1:0]         t_prio;
  logic                      g_irq;
  prir_res_t                 res_d, res_q;

  prir_unpack #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .WORD_W(WORD_W)) u_unpack (
    .words_i (prio_words_i),
    .prio_o  (prio_flat)
  );

  prir_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_tree (
    .clk        (clk),
    .rst_n      (rst_n),
    .elig_i     (elig_i),
    .prio_i     (prio_flat),
    .win_vld_o  (t_vld),
    .win_idx_o  (t_idx),
    .win_prio_o (t_prio)
  );

  prir_irq_gate #(.PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_i      (t_vld),
    .max_prio_i (t_prio),
    .mask_i     (mask_i),
    .irq_o      (g_irq)
  );

  // Next state: an empty result reads as all ones
  always_comb begin
    res_d.irq  = g_irq;
    res_d.vld  = t_vld;
    res_d.idx  = t_vld ? t_idx  : '1;
    res_d.prio = t_vld ? t_prio : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q.irq  <= 1'b0;
      res_q.vld  <= 1'b0;
      res_q.idx  <= '1;
      res_q.prio <= '1;
    end else begin
      res_q <= res_d;
    end
  end

  always_comb begin
    irq_o      = res_q.irq;
    win_vld_o  = res_q.vld;
    win_idx_o  = res_q.idx;
    win_prio_o = res_q.prio;
    if (res_q.vld) begin
      win_packed_o = '0;
      win_packed_o[IDX_LSB +: IDX_W] = res_q.idx;
      win_packed_o[PRIO_W-1:0]       = res_q.prio;
    end else begin
      win_packed_o = '1;
    end
  end

  AST_IRQ_NEEDS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> win_vld_o); // R8
  AST_IDLE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld_o |-> (win_packed_o == '1 && !irq_o)); // R5
  AST_PACKED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> (win_packed_o[IDX_LSB +: IDX_W] == win_idx_o &&
                   win_packed_o[PRIO_W-1:0] == win_prio_o)); // R6
  AST_OUT_FOLLOWS_TREE: assert property (@(posedge clk) disable iff (!rst_n)
    t_vld |=> win_vld_o); // R1
endmodule

// File: tb/prio_irq_resolver_tb.sv
module prio_irq_resolver_tb;
  localparam int N  = 64;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  elig;
  logic [NW*32-1:0] pw;
  logic [4:0]    mask;
  logic          irq_o, win_vld_o;
  logic [5:0]    win_idx_o;
  logic [3:0]    win_prio_o;
  logic [31:0]   win_packed_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prio_irq_resolver u_dut (
    .clk (clk), .rst_n (rst_n), .elig_i (elig), .prio_words_i (pw), .mask_i (mask),
    .irq_o (irq_o), .win_vld_o (win_vld_o), .win_idx_o (win_idx_o),
    .win_prio_o (win_prio_o), .win_packed_o (win_packed_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_prio(input int n, input logic [3:0] p);
    pw[32*(n/8) + 4*(n%8) +: 4] = p;
  endtask

  // Reference: scan all sources, keep the last one with the largest priority
  task automatic check_outputs(input string req);
    int bi, bp;
    logic e_irq;
    logic [31:0] e_pk;
    bi = -1; bp = -1;
    for (int n = 0; n < N; n++) begin
      int p;
      p = int'(pw[32*(n/8) + 4*(n%8) +: 4]);
      if (elig[n] && p >= bp) begin bp = p; bi = n; end
    end
    if (bi < 0) begin
      e_irq = 1'b0;
      chk(req, "vld", {31'b0, win_vld_o}, 32'd0);
      chk(req, "idx", {26'b0, win_idx_o}, 32'h3F);
      chk(req, "prio", {28'b0, win_prio_o}, 32'hF);
      chk(req, "packed", win_packed_o, 32'hFFFF_FFFF);
    end else begin
      e_irq = (mask == 5'h1F) || (bp > int'(mask));
      e_pk  = (32'(bi) << 16) | 32'(bp);
      chk(req, "vld", {31'b0, win_vld_o}, 32'd1);
      chk(req, "idx", {26'b0, win_idx_o}, 32'(bi));
      chk(req, "prio", {28'b0, win_prio_o}, 32'(bp));
      chk(req, "packed", win_packed_o, e_pk);
    end
    chk(req, "irq", {31'b0, irq_o}, {31'b0, e_irq});
  endtask

  task automatic apply(input string req);
    @(posedge clk);
    @(negedge clk);
    check_outputs(req);
  endtask

  task automatic clear_inputs();
    elig = '0; pw = '0; mask = 5'd0;
  endtask

  task automatic t_reset();
    chk("R1", "rst irq", {31'b0, irq_o}, 32'd0);
    chk("R1", "rst vld", {31'b0, win_vld_o}, 32'd0);
    chk("R1", "rst idx", {26'b0, win_idx_o}, 32'h3F);
    chk("R1", "rst prio", {28'b0, win_prio_o}, 32'hF);
    chk("R1", "rst packed", win_packed_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_none();  // R5
    @(negedge clk); clear_inputs(); pw = '1; mask = 5'd0;
    apply("R5");
  endtask

  task automatic t_single();  // R2, R6, R8
    @(negedge clk); clear_inputs();
    elig[45] = 1'b1; set_prio(45, 4'd7); mask = 5'd3;
    apply("R2");
    chk("R6", "packed literal", win_packed_o, 32'h002D_0007);
    chk("R8", "irq above", {31'b0, irq_o}, 32'd1);
  endtask

  task automatic t_max();  // R3
    @(negedge clk); clear_inputs();
    elig[3] = 1; set_prio(3, 4'd2);
    elig[17] = 1; set_prio(17, 4'd11);
    elig[50] = 1; set_prio(50, 4'd5);
    elig[63] = 1; set_prio(63, 4'd1);
    mask = 5'd0;
    apply("R3");
    chk("R3", "winner 17", {26'b0, win_idx_o}, 32'd17);
  endtask

  task automatic t_tie();  // R4
    @(negedge clk); clear_inputs();
    elig[0] = 1; set_prio(0, 4'd9);
    elig[10] = 1; set_prio(10, 4'd9);
    elig[40] = 1; set_prio(40, 4'd9);
    elig[62] = 1; set_prio(62, 4'd9);
    elig[31] = 1; set_prio(31, 4'd4);
    apply("R4");
    chk("R4", "tie high idx", {26'b0, win_idx_o}, 32'd62);
    @(negedge clk); elig[62] = 0;
    apply("R4");
    chk("R4", "tie next idx", {26'b0, win_idx_o}, 32'd40);
  endtask

  task automatic t_mask_edge();  // R8
    @(negedge clk); clear_inputs();
    elig[20] = 1; set_prio(20, 4'd6); mask = 5'd6;
    apply("R8");
    chk("R8", "equal no irq", {31'b0, irq_o}, 32'd0);
    @(negedge clk); mask = 5'd5;
    apply("R8");
    chk("R8", "one below irq", {31'b0, irq_o}, 32'd1);
  endtask

  task automatic t_mask_open();  // R7
    @(negedge clk); clear_inputs();
    elig[0] = 1; elig[33] = 1; mask = 5'h1F;
    apply("R7");
    chk("R7", "open mask prio0", {31'b0, irq_o}, 32'd1);
    @(negedge clk); mask = 5'd0;
    apply("R8");
    chk("R8", "prio0 mask0", {31'b0, irq_o}, 32'd0);
  endtask

  task automatic t_mask_high();  // R9
    @(negedge clk); clear_inputs(); pw = '1; elig = '1; mask = 5'd16;
    apply("R9");
    chk("R9", "mask16", {31'b0, irq_o}, 32'd0);
    @(negedge clk); mask = 5'd30;
    apply("R9");
    chk("R9", "mask30", {31'b0, irq_o}, 32'd0);
  endtask

  task automatic t_inelig();  // R10
    @(negedge clk); clear_inputs(); pw = '1;
    set_prio(1, 4'd2); elig[1] = 1; mask = 5'd1;
    apply("R10");
    chk("R10", "masked-out high prio ignored", {26'b0, win_idx_o}, 32'd1);
    chk("R10", "prio of eligible", {28'b0, win_prio_o}, 32'd2);
  endtask

  task automatic t_latency();  // R1
    @(negedge clk); clear_inputs(); elig[7] = 1; set_prio(7, 4'd3);
    apply("R1");
    @(negedge clk); elig = '0; elig[56] = 1; set_prio(56, 4'd12);
    #3;
    chk("R1", "held before edge", {26'b0, win_idx_o}, 32'd7);
    apply("R1");
    chk("R1", "updated after edge", {26'b0, win_idx_o}, 32'd56);
  endtask

  task automatic t_sweep();  // R3, R4, R8
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      elig = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      for (int w = 0; w < NW; w++) pw[32*w +: 32] = $urandom() & 32'h3333_3333;
      mask = 5'($urandom() % 32);
      apply("R3");
    end
  endtask

  initial begin
    rst_n = 1'b0;
    clear_inputs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_none();
    t_single();
    t_max();
    t_tie();
    t_mask_edge();
    t_mask_open();
    t_mask_high();
    t_inelig();
    t_latency();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule